// File: doc/BRIEF.md
# Predicated Register File with Program Counter Slot

This block is the architectural register store of a small single-issue processor. It holds sixteen 32-bit registers. Two of them are special: index 14 is the program counter, and index 15 is a side register that only the secondary result path of the execute stage can load. Two read ports feed the operand buses combinationally. One write port takes the primary result bus. Whether that write happens depends on a 3-bit writeback condition, which is tested against a stored sign status of an earlier result.

The sign status is a three-state machine with the states `SG_POS`, `SG_ZERO` and `SG_NEG`. Reset leaves it in `SG_POS`, which means no flag is set. When the compare bit is high, the state moves at the clock edge to the state that matches the signed value on the result bus. The transitions are `cmp_zero`, `cmp_neg` and `cmp_pos`. When the compare bit is low, the state holds (`keep`). Because the state only changes at the edge, an instruction that updates the status is itself predicated by the status left by earlier instructions.

A predicated write to index 14 acts as a jump. The `jump` output is raised in that cycle, and the program counter takes the result value at the next edge. In every other cycle the counter steps by one while `advance` is high.

Top module: `cwb_regfile`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears every register, including the program counter and index 15. It also puts the status in `SG_POS`: no zero flag and no negative flag, so the codes "nonzero" and "greater or equal" hold.
- R2: Both read ports are combinational. A select of 14 returns the current program counter, a select of 15 returns the side register, and any other select returns that general register.
- R3: When the writeback condition holds and `wr_sel` is between 0 and 13, the register at `wr_sel` takes `res_bus` at the clock edge. No other general register changes.
- R4: Writeback condition codes on `wr_cond`: 0 never; 1 always; 2 when the status is zero; 3 when it is not zero; 4 when it is zero or positive; 5 when it is negative; 6 and 7 never.
- R5: With `cmp_en` high, the status takes the sign of `res_bus` (read as a signed 32-bit value) at the clock edge. The condition for that same cycle's write uses the status from before the edge.
- R6: With `cmp_en` low, the status does not change.
- R7: When the condition holds and `wr_sel` is 14, `jump` is high in that cycle and the program counter equals `res_bus` after the edge, whatever the value of `advance`.
- R8: When no jump takes place, the program counter increases by one per edge while `advance` is high and holds while it is low.
- R9: A write to index 15 through `wr_sel` has no effect, even when the condition holds.
- R10: With `aux_valid` high, index 15 takes `aux_bus` at the edge, whatever the writeback condition is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| advance | input | 1 | Step the program counter when no jump occurs |
| rd_a_sel | input | 4 | Read select for operand A |
| rd_b_sel | input | 4 | Read select for operand B |
| wr_sel | input | 4 | Destination select for the result bus |
| wr_cond | input | 3 | Writeback condition code |
| cmp_en | input | 1 | Latch the sign of the result bus into the status |
| res_bus | input | 32 | Primary result |
| aux_bus | input | 32 | Secondary result for index 15 |
| aux_valid | input | 1 | Load index 15 from `aux_bus` |
| op_a | output | 32 | Operand A read data |
| op_b | output | 32 | Operand B read data |
| pc | output | 32 | Current program counter |
| jump | output | 1 | A predicated write to index 14 is taking effect |

## Verification
The bench builds the block with its default parameters: 32-bit data and 16 registers. With these values the sign bit sits at bit 31, and the select values 14 and 15 reach the counter slot and the side-register slot. The bench drives each of the eight condition codes after compares that leave the status zero, positive and negative. It also drives a compare and a predicated write in the same cycle, jumps with `advance` both high and low, and a direct write to index 15. A seeded mixed sequence follows, and a reference model is compared against all outputs on every clock.

// File: rtl/cwb_pkg.sv
package cwb_pkg;

    typedef enum logic [2:0] {
        WC_NEVER   = 3'd0,
        WC_ALWAYS  = 3'd1,
        WC_ZERO    = 3'd2,
        WC_NONZERO = 3'd3,
        WC_GEZ     = 3'd4,
        WC_LTZ     = 3'd5,
        WC_RSV6    = 3'd6,
        WC_RSV7    = 3'd7
    } wb_cond_e;

    typedef enum logic [1:0] {
        SG_POS  = 2'd0,
        SG_ZERO = 2'd1,
        SG_NEG  = 2'd2
    } sgn_state_e;

endpackage

// File: rtl/cwb_status.sv
module cwb_status
    import cwb_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cmp_en,
    input  logic [DW-1:0] res_bus,
    input  logic [2:0]    cond,
    output logic          wb_ok
);

    sgn_state_e state_q, state_d;

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= SG_POS;
        else     state_q <= state_d;
    end

    // transitions: keep / cmp_zero / cmp_neg / cmp_pos
    always_comb begin
        state_d = state_q;
        if (cmp_en) begin
            if (res_bus == '0)        state_d = SG_ZERO;
            else if (res_bus[DW-1])   state_d = SG_NEG;
            else                      state_d = SG_POS;
        end
    end

    // outputs: predicate from the stored state
    always_comb begin
        wb_ok = 1'b0;
        unique case (wb_cond_e'(cond))
            WC_NEVER:   wb_ok = 1'b0;
            WC_ALWAYS:  wb_ok = 1'b1;
            WC_ZERO:    wb_ok = (state_q == SG_ZERO);
            WC_NONZERO: wb_ok = (state_q != SG_ZERO);
            WC_GEZ:     wb_ok = (state_q != SG_NEG);
            WC_LTZ:     wb_ok = (state_q == SG_NEG);
            WC_RSV6:    wb_ok = 1'b0;
            WC_RSV7:    wb_ok = 1'b0;
        endcase
    end

    p_cmp_zero_r5: assert property (@(posedge clk) disable iff (rst)
        (cmp_en && res_bus == '0) |=> state_q == SG_ZERO);
    p_cmp_neg_r5: assert property (@(posedge clk) disable iff (rst)
        (cmp_en && res_bus[DW-1]) |=> state_q == SG_NEG);
    p_keep_r6: assert property (@(posedge clk) disable iff (rst)
        !cmp_en |=> $stable(state_q));
    p_rsv_never_r4: assert property (@(posedge clk) disable iff (rst)
        (cond == 3'd6 || cond == 3'd7 || cond == 3'd0) |-> !wb_ok);

endmodule

// File: rtl/cwb_pc.sv
module cwb_pc #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          advance,
    input  logic          load,
    input  logic [DW-1:0] load_val,
    output logic [DW-1:0] pc
);

    logic [DW-1:0] pc_q;

    always_ff @(posedge clk) begin
        if (rst)          pc_q <= '0;
        else if (load)    pc_q <= load_val;
        else if (advance) pc_q <= pc_q + DW'(1);
    end

    assign pc = pc_q;

    p_step_r8: assert property (@(posedge clk) disable iff (rst)
        (!load && advance) |=> pc_q == $past(pc_q) + DW'(1));
    p_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (!load && !advance) |=> $stable(pc_q));

endmodule

// File: rtl/cwb_regbank.sv
module cwb_regbank #(
    parameter int DW   = 32,
    parameter int NREG = 16,
    parameter int SELW = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_en,
    input  logic [SELW-1:0] wr_sel,
    input  logic [DW-1:0]   wr_data,
    input  logic            aux_valid,
    input  logic [DW-1:0]   aux_data,
    input  logic [DW-1:0]   pc_val,
    input  logic [SELW-1:0] rd_a_sel,
    input  logic [SELW-1:0] rd_b_sel,
    output logic [DW-1:0]   op_a,
    output logic [DW-1:0]   op_b
);

    localparam int PC_IDX = NREG - 2;
    localparam int RX_IDX = NREG - 1;

    logic [DW-1:0] view [NREG];
    logic [DW-1:0] rx_q;

    always_ff @(posedge clk) begin
        if (rst)            rx_q <= '0;
        else if (aux_valid) rx_q <= aux_data;
    end

    for (genvar i = 0; i < NREG; i++) begin : g_slot
        if (i < PC_IDX) begin : g_gpr
            logic [DW-1:0] q;
            always_ff @(posedge clk) begin
                if (rst)                                 q <= '0;
                else if (wr_en && wr_sel == SELW'(i))    q <= wr_data;
            end
            assign view[i] = q;
        end else if (i == PC_IDX) begin : g_pc
            assign view[i] = pc_val;
        end else begin : g_rx
            assign view[i] = rx_q;
        end
    end

    assign op_a = view[rd_a_sel];
    assign op_b = view[rd_b_sel];

    p_rx_load_r10: assert property (@(posedge clk) disable iff (rst)
        aux_valid |=> rx_q == $past(aux_data));
    p_rx_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !aux_valid |=> $stable(rx_q));

endmodule

// File: rtl/cwb_regfile.sv
module cwb_regfile #(
    parameter int DW   = 32,
    parameter int NREG = 16,
    localparam int SELW = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            advance,
    input  logic [SELW-1:0] rd_a_sel,
    input  logic [SELW-1:0] rd_b_sel,
    input  logic [SELW-1:0] wr_sel,
    input  logic [2:0]      wr_cond,
    input  logic            cmp_en,
    input  logic [DW-1:0]   res_bus,
    input  logic [DW-1:0]   aux_bus,
    input  logic            aux_valid,
    output logic [DW-1:0]   op_a,
    output logic [DW-1:0]   op_b,
    output logic [DW-1:0]   pc,
    output logic            jump
);

    localparam int PC_IDX = NREG - 2;

    logic wb_ok;

    cwb_status #(.DW(DW)) u_status (
        .clk     (clk),
        .rst     (rst),
        .cmp_en  (cmp_en),
        .res_bus (res_bus),
        .cond    (wr_cond),
        .wb_ok   (wb_ok)
    );

    assign jump = wb_ok && (wr_sel == SELW'(PC_IDX));

    cwb_pc #(.DW(DW)) u_pc (
        .clk      (clk),
        .rst      (rst),
        .advance  (advance),
        .load     (jump),
        .load_val (res_bus),
        .pc       (pc)
    );

    cwb_regbank #(.DW(DW), .NREG(NREG), .SELW(SELW)) u_bank (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wb_ok),
        .wr_sel    (wr_sel),
        .wr_data   (res_bus),
        .aux_valid (aux_valid),
        .aux_data  (aux_bus),
        .pc_val    (pc),
        .rd_a_sel  (rd_a_sel),
        .rd_b_sel  (rd_b_sel),
        .op_a      (op_a),
        .op_b      (op_b)
    );

    p_jump_pc_r7: assert property (@(posedge clk) disable iff (rst)
        jump |=> pc == $past(res_bus));

endmodule

// File: tb/cwb_regfile_test.sv
module cwb_regfile_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        advance = 1'b0;
    logic [3:0]  rd_a_sel = '0, rd_b_sel = '0, wr_sel = '0;
    logic [2:0]  wr_cond = '0;
    logic        cmp_en = 1'b0;
    logic [31:0] res_bus = '0, aux_bus = '0;
    logic        aux_valid = 1'b0;
    logic [31:0] op_a, op_b, pc;
    logic        jump;

    int total = 0;
    int bad = 0;
    string tag = "R1";

    // reference model state
    logic [31:0] m_reg [16];
    int          m_stat;     // 0 pos, 1 zero, 2 neg
    logic [31:0] m_pc;

    always #4 clk = ~clk;

    cwb_regfile uut (
        .clk(clk), .rst(rst), .advance(advance),
        .rd_a_sel(rd_a_sel), .rd_b_sel(rd_b_sel), .wr_sel(wr_sel),
        .wr_cond(wr_cond), .cmp_en(cmp_en), .res_bus(res_bus),
        .aux_bus(aux_bus), .aux_valid(aux_valid),
        .op_a(op_a), .op_b(op_b), .pc(pc), .jump(jump)
    );

    function automatic bit m_ok(input logic [2:0] c);
        case (c)
            3'd1: return 1'b1;
            3'd2: return m_stat == 1;
            3'd3: return m_stat != 1;
            3'd4: return m_stat != 2;
            3'd5: return m_stat == 2;
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic [31:0] m_read(input logic [3:0] s);
        return (s == 4'd14) ? m_pc : m_reg[s];
    endfunction

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // one cycle: drive at negedge, compare outputs, then update model at posedge
    task automatic cyc(input logic r, input logic adv, input logic [3:0] ra, input logic [3:0] rb,
                       input logic [3:0] ws, input logic [2:0] wc, input logic ce,
                       input logic [31:0] res, input logic av, input logic [31:0] ax);
        bit ok;
        @(negedge clk);
        rst = r; advance = adv; rd_a_sel = ra; rd_b_sel = rb; wr_sel = ws;
        wr_cond = wc; cmp_en = ce; res_bus = res; aux_valid = av; aux_bus = ax;
        #1;
        chk("op_a", op_a, m_read(ra));
        chk("op_b", op_b, m_read(rb));
        chk("pc", pc, m_pc);
        ok = m_ok(wc);
        if (!r) chk("jump", {31'd0, jump}, {31'd0, ok && ws == 4'd14});
        @(posedge clk);
        if (r) begin
            for (int i = 0; i < 16; i++) m_reg[i] = '0;
            m_pc = '0; m_stat = 0;
        end else begin
            if (ok && ws < 4'd14) m_reg[ws] = res;
            if (av) m_reg[15] = ax;
            if (ok && ws == 4'd14) m_pc = res;
            else if (adv) m_pc = m_pc + 1;
            if (ce) m_stat = (res == 0) ? 1 : (res[31] ? 2 : 0);
        end
    endtask

    task automatic set_stat(input logic [31:0] v);
        cyc(0, 0, 0, 0, 0, 3'd0, 1, v, 0, 0);
    endtask

    initial begin
        #(8 * 200000);
        bad++; total++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 16; i++) m_reg[i] = '0;
        m_pc = '0; m_stat = 0;
        // R1: reset state of all slots and status (nonzero / ge hold)
        tag = "R1";
        cyc(1, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        for (int i = 0; i < 16; i++) cyc(0, 0, 4'(i), 4'(15 - i), 0, 0, 0, 0, 0, 0);
        cyc(0, 0, 0, 0, 4'd1, 3'd3, 0, 32'h11, 0, 0);
        cyc(0, 0, 0, 0, 4'd2, 3'd4, 0, 32'h22, 0, 0);
        cyc(0, 0, 0, 0, 4'd3, 3'd2, 0, 32'h33, 0, 0);
        cyc(0, 0, 1, 2, 4'd3, 3'd5, 0, 32'h44, 0, 0);
        cyc(0, 0, 3, 3, 0, 0, 0, 0, 0, 0);
        // R3, R2: fill general registers and read back on both ports
        tag = "R3";
        for (int i = 0; i < 14; i++) cyc(0, 0, 4'(i), 4'(13 - i), 4'(i), 3'd1, 0, 32'hA000_0000 + i, 0, 0);
        tag = "R2";
        for (int i = 0; i < 16; i++) cyc(0, 1, 4'(i), 4'(15 - i), 0, 0, 0, 0, 0, 0);
        // R4: every code against zero, positive and negative status
        tag = "R4";
        foreach (m_reg[k]) if (k < 3) begin
            set_stat(k == 0 ? 32'd0 : (k == 1 ? 32'd7 : 32'hFFFF_FFF0));
            for (int c = 0; c < 8; c++) begin
                cyc(0, 0, 5, 5, 4'd5, 3'(c), 0, 32'h5000_0000 + 32'(k * 16 + c), 0, 0);
                cyc(0, 0, 5, 5, 0, 0, 0, 0, 0, 0);
            end
        end
        // R5: same-cycle compare uses prior status
        tag = "R5";
        set_stat(32'd9);
        cyc(0, 0, 6, 6, 4'd6, 3'd2, 1, 32'd0, 0, 0);
        cyc(0, 0, 6, 6, 4'd6, 3'd2, 0, 32'h66, 0, 0);
        cyc(0, 0, 6, 6, 4'd6, 3'd5, 1, 32'h8000_0000, 0, 0);
        cyc(0, 0, 6, 6, 4'd6, 3'd5, 0, 32'h67, 0, 0);
        cyc(0, 0, 6, 6, 0, 0, 0, 0, 0, 0);
        // R6: status kept without compare
        tag = "R6";
        cyc(0, 0, 7, 7, 4'd7, 3'd1, 0, 32'd0, 0, 0);
        cyc(0, 0, 7, 7, 4'd7, 3'd5, 0, 32'h77, 0, 0);
        cyc(0, 0, 7, 7, 0, 0, 0, 0, 0, 0);
        // R7: jumps with advance high and low, and a failed conditional jump
        tag = "R7";
        cyc(0, 1, 14, 14, 4'd14, 3'd1, 0, 32'h0000_1234, 0, 0);
        cyc(0, 0, 14, 14, 4'd14, 3'd1, 0, 32'h0000_0040, 0, 0);
        cyc(0, 1, 14, 14, 4'd14, 3'd2, 0, 32'h0000_9999, 0, 0);
        cyc(0, 0, 14, 14, 0, 0, 0, 0, 0, 0);
        // R8: stepping and holding
        tag = "R8";
        for (int i = 0; i < 6; i++) cyc(0, i[0], 14, 0, 0, 0, 0, 0, 0, 0);
        // R9: direct write to index 15 is ignored
        tag = "R9";
        cyc(0, 0, 15, 15, 4'd15, 3'd1, 0, 32'hDEAD_BEEF, 0, 0);
        cyc(0, 0, 15, 15, 0, 0, 0, 0, 0, 0);
        // R10: secondary path loads index 15 regardless of condition
        tag = "R10";
        cyc(0, 0, 15, 15, 4'd15, 3'd0, 0, 32'h1, 1, 32'hCAFE_0001);
        cyc(0, 0, 15, 15, 4'd15, 3'd1, 0, 32'h2, 1, 32'hCAFE_0002);
        cyc(0, 0, 15, 15, 0, 0, 0, 0, 0, 0);
        // mixed sequence
        tag = "R3";
        void'($urandom(32'd17));
        for (int i = 0; i < 400; i++)
            cyc(0, 1'($urandom), 4'($urandom), 4'($urandom), 4'($urandom), 3'($urandom),
                1'($urandom), ($urandom % 3 == 0) ? 32'd0 : $urandom, 1'($urandom % 4 == 0), $urandom);
        // R1: reset again
        tag = "R1";
        cyc(1, 1, 0, 0, 0, 0, 0, 0, 0, 0);
        for (int i = 0; i < 16; i++) cyc(0, 0, 4'(i), 4'(i), 0, 0, 0, 0, 0, 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule